// File: doc/BRIEF.md
# Motor driver fault supervisor

This block watches four fault conditions of an H-bridge motor driver: a sustained current limit, a hard overcurrent, over-temperature and supply undervoltage. Each arrives as a 1-bit level that has already been synchronised to the system clock. Analog sensing and threshold comparison happen outside the block. The block filters each condition, keeps the status flags read by the register interface, decides whether the bridge must be switched off, and drives the open-drain fault pin.

Each fault source has its own policy. A current-limit event is filtered by a long persistence timer and only reports: the bridge keeps driving. A hard overcurrent is filtered by a short deglitch timer and latches the bridge off until software clears it. Over-temperature and undervoltage are live conditions that disable the bridge while present and release it on their own. The two direction bits of the control register feed back into the block. They clear the current-limit flag when the bridge is put into coast or brake, and they trigger a short pulse on the fault pin when the driver leaves sleep. All timer lengths are parameters counted in system-clock cycles.

Top module: `mfs_fault_supervisor`

## Requirements
- R1: The current-limit flag (status bit 4) is set on the rising clock edge that follows `ILIM_PERSIST_CYC` consecutive sampled-high cycles of `ilim_cond_i`. A high run of `ILIM_PERSIST_CYC-1` cycles leaves it clear. Once set, it stays set after the condition drops.
- R2: A current-limit flag alone never asserts `bridge_off_o`.
- R3: The current-limit flag is cleared on any clock edge where `flt_clear_i` is high or `drive_dir_i` is 2'b00 (coast/sleep) or 2'b11 (brake).
- R4: The overcurrent flag (status bit 1) is set on the edge after `OCP_DEGLITCH_CYC` consecutive high cycles of `ocp_cond_i`, and it asserts `bridge_off_o`. A shorter run has no effect.
- R5: The overcurrent flag stays set through any change of `drive_dir_i`, including sleep. Only an edge with `flt_clear_i` high clears it.
- R6: The over-temperature flag (status bit 3) follows `ots_cond_i` one cycle later and asserts `bridge_off_o` while set. It releases without any clear.
- R7: The undervoltage flag (status bit 2) follows `uv_cond_i` one cycle later and asserts `bridge_off_o` while set. It releases without any clear.
- R8: Status bit 0 is high exactly when any of status bits 1 to 4 is high.
- R9: An edge that samples `drive_dir_i` leaving 2'b00 starts a fault-pin pulse. The pulse is high for `WAKE_PULSE_CYC` cycles after that edge.
- R10: `fault_pull_o` (1 means pull the pin low) is high while any status bit or the wake pulse is active.
- R11: After reset, all status bits, `bridge_off_o` and `fault_pull_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ilim_cond_i | input | 1 | Current-limit comparator level, synchronised |
| ocp_cond_i | input | 1 | Overcurrent comparator level, synchronised |
| ots_cond_i | input | 1 | Over-temperature level, synchronised |
| uv_cond_i | input | 1 | Undervoltage level, synchronised |
| drive_dir_i | input | 2 | Direction bits: bit 0 forward, bit 1 reverse; 00 sleep, 11 brake |
| flt_clear_i | input | 1 | Single-cycle clear pulse from the register write |
| status_o | output | 5 | {ilim, ots, uv, ocp, any} |
| bridge_off_o | output | 1 | Disable every bridge switch |
| fault_pull_o | output | 1 | Drive enable for the open-drain fault pin (1 = pull low) |

## Verification
The hardest situation to reach is the overcurrent latch surviving a trip through sleep and back out. In that case the wake pulse and the latched flag both hold the fault pin, so the pin alone cannot show that the latch held. The stimulus therefore trips the overcurrent and drops the condition. It then parks the direction bits at coast, leaves sleep and waits out the wake pulse, and checks that the status bit and bridge disable are still set before issuing the clear pulse. Persistence boundaries are reached by holding each condition exactly one cycle short of its timer, then exactly long enough.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

  // Status vector bit positions (decoded by the register interface)
  localparam int ST_ANY  = 0;
  localparam int ST_OCP  = 1;
  localparam int ST_UV   = 2;
  localparam int ST_OTS  = 3;
  localparam int ST_ILIM = 4;
  localparam int ST_W    = 5;

  typedef enum logic [1:0] {
    DIR_SLEEP = 2'b00,
    DIR_FWD   = 2'b01,
    DIR_REV   = 2'b10,
    DIR_BRAKE = 2'b11
  } drive_dir_e;

  // Coast and brake both remove the driven current: both clear current limit
  function automatic logic dir_clears_ilim(input logic [1:0] dir);
    return dir[0] == dir[1];
  endfunction

  function automatic logic any_fault(input logic ocp, input logic uv,
                                     input logic ots, input logic ilim);
    return ocp | uv | ots | ilim;
  endfunction

endpackage

// File: rtl/mfs_persist_timer.sv
module mfs_persist_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  output logic hit_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CMAX = CW'(LIMIT);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else if (!cond_i)
      run_q <= '0;
    else if (run_q != CMAX)
      run_q <= run_q + 1'b1;
  end

  assign hit_o = (run_q == CMAX);

  p_run_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= CMAX);

  p_run_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_i |=> !hit_o);

endmodule

// File: rtl/mfs_wake_pulse.sv
module mfs_wake_pulse
  import mfs_pkg::*;
#(
  parameter int PULSE_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] dir_i,
  output logic       active_o
);
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam logic [PW-1:0] PLEN = PW'(PULSE_CYC);

  logic [1:0]    dir_q;
  logic [PW-1:0] left_q;
  logic          wake_start;

  assign wake_start = (dir_q == DIR_SLEEP) && (dir_i != DIR_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= DIR_SLEEP;
      left_q <= '0;
    end else begin
      dir_q <= dir_i;
      if (wake_start)
        left_q <= PLEN;
      else if (left_q != '0)
        left_q <= left_q - 1'b1;
    end
  end

  assign active_o = (left_q != '0);

  p_wake_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_start |=> active_o);

  p_wake_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= PLEN);

endmodule

// File: rtl/mfs_fault_supervisor.sv
module mfs_fault_supervisor
  import mfs_pkg::*;
#(
  parameter int ILIM_PERSIST_CYC = 64,
  parameter int OCP_DEGLITCH_CYC = 8,
  parameter int WAKE_PULSE_CYC   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ilim_cond_i,
  input  logic            ocp_cond_i,
  input  logic            ots_cond_i,
  input  logic            uv_cond_i,
  input  logic [1:0]      drive_dir_i,
  input  logic            flt_clear_i,
  output logic [ST_W-1:0] status_o,
  output logic            bridge_off_o,
  output logic            fault_pull_o
);

  logic ilim_hit, ocp_hit, wake_active, ilim_clear_evt;
  logic st_ilim_q, st_ocp_q, st_ots_q, st_uv_q;

  mfs_persist_timer #(.LIMIT(ILIM_PERSIST_CYC)) i_ilim_timer (
    .clk(clk), .rst_n(rst_n), .cond_i(ilim_cond_i), .hit_o(ilim_hit));

  mfs_persist_timer #(.LIMIT(OCP_DEGLITCH_CYC)) i_ocp_timer (
    .clk(clk), .rst_n(rst_n), .cond_i(ocp_cond_i), .hit_o(ocp_hit));

  mfs_wake_pulse #(.PULSE_CYC(WAKE_PULSE_CYC)) i_wake (
    .clk(clk), .rst_n(rst_n), .dir_i(drive_dir_i), .active_o(wake_active));

  assign ilim_clear_evt = flt_clear_i | dir_clears_ilim(drive_dir_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_ilim_q <= 1'b0;
      st_ocp_q  <= 1'b0;
      st_ots_q  <= 1'b0;
      st_uv_q   <= 1'b0;
    end else begin
      st_ilim_q <= ilim_clear_evt ? 1'b0 : (st_ilim_q | ilim_hit);
      st_ocp_q  <= flt_clear_i    ? 1'b0 : (st_ocp_q  | ocp_hit);
      st_ots_q  <= ots_cond_i;
      st_uv_q   <= uv_cond_i;
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[ST_OCP]  = st_ocp_q;
    status_o[ST_UV]   = st_uv_q;
    status_o[ST_OTS]  = st_ots_q;
    status_o[ST_ILIM] = st_ilim_q;
    status_o[ST_ANY]  = any_fault(st_ocp_q, st_uv_q, st_ots_q, st_ilim_q);
  end

  assign bridge_off_o = st_ocp_q | st_ots_q | st_uv_q;
  assign fault_pull_o = status_o[ST_ANY] | wake_active;

  p_ilim_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[ST_ILIM] && !status_o[ST_OCP] && !status_o[ST_OTS] && !status_o[ST_UV])
      |-> !bridge_off_o);

  p_ilim_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_clear_evt |=> !status_o[ST_ILIM]);

  p_ocp_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[ST_OCP] |-> bridge_off_o);

  p_ocp_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[ST_OCP] && !flt_clear_i) |=> status_o[ST_OCP]);

  p_ots_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ots_cond_i |=> (status_o[ST_OTS] && bridge_off_o));

  p_uv_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_cond_i |=> !status_o[ST_UV]);

  p_any_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status_o[ST_W-1:1]) != 0 |-> status_o[ST_ANY]);

  p_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o != '0 || wake_active) |-> fault_pull_o);

endmodule

// File: tb/test_mfs_fault_supervisor.sv
`timescale 1ns/1ps
module test_mfs_fault_supervisor;

  localparam int ILIM_N = 20;
  localparam int OCP_N  = 5;
  localparam int WAKE_N = 6;

  // status layout: [0] any, [1] ocp, [2] uv, [3] ots, [4] ilim
  localparam logic [4:0] S_NONE = 5'b00000;
  localparam logic [4:0] S_OCP  = 5'b00011;
  localparam logic [4:0] S_UV   = 5'b00101;
  localparam logic [4:0] S_OTS  = 5'b01001;
  localparam logic [4:0] S_ILIM = 5'b10001;

  typedef struct {
    string      tag;
    logic [4:0] st;
    logic       br;
    logic       pin;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ilim_c = 0, ocp_c = 0, ots_c = 0, uv_c = 0, clr = 0;
  logic [1:0] dir = 2'b00;
  logic [4:0] status;
  logic bridge_off, fault_pull;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  mfs_fault_supervisor #(
    .ILIM_PERSIST_CYC(ILIM_N), .OCP_DEGLITCH_CYC(OCP_N), .WAKE_PULSE_CYC(WAKE_N)
  ) i_mfs_fault_supervisor (
    .clk(clk), .rst_n(rst_n),
    .ilim_cond_i(ilim_c), .ocp_cond_i(ocp_c), .ots_cond_i(ots_c), .uv_cond_i(uv_c),
    .drive_dir_i(dir), .flt_clear_i(clr),
    .status_o(status), .bridge_off_o(bridge_off), .fault_pull_o(fault_pull));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic [4:0] st,
                            input logic br, input logic pin);
    exp_t e;
    e.tag = tag; e.st = st; e.br = br; e.pin = pin;
    sb_q.push_back(e);
  endtask

  // Monitor: compares just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (status !== e.st || bridge_off !== e.br || fault_pull !== e.pin) begin
          failures++;
          $display("FAIL %s: got st=%b br=%b pin=%b, expected st=%b br=%b pin=%b",
                   e.tag, status, bridge_off, fault_pull, e.st, e.br, e.pin);
        end
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    expect_out("R11 reset state", S_NONE, 0, 0);

    // R9: wake pulse on leaving sleep
    dir = 2'b01;
    tick(1);
    expect_out("R9 wake pulse start", S_NONE, 0, 1);
    tick(WAKE_N - 1);
    expect_out("R9 wake pulse last cycle", S_NONE, 0, 1);
    tick(1);
    expect_out("R9 wake pulse ended", S_NONE, 0, 0);

    // R1: one cycle short of persistence
    ilim_c = 1; tick(ILIM_N - 1); ilim_c = 0; tick(3);
    expect_out("R1 short current-limit run ignored", S_NONE, 0, 0);

    // R1/R2/R10: full persistence
    ilim_c = 1; tick(ILIM_N);
    expect_out("R1 not yet set at limit edge", S_NONE, 0, 0);
    tick(1);
    expect_out("R2 R10 current limit set, bridge on", S_ILIM, 0, 1);
    ilim_c = 0; tick(2);
    expect_out("R1 current limit sticky", S_ILIM, 0, 1);

    // R3: clear pulse
    clr = 1; tick(1); clr = 0;
    expect_out("R3 cleared by clear pulse", S_NONE, 0, 0);

    // R3: brake clears
    ilim_c = 1; tick(ILIM_N + 1); ilim_c = 0;
    expect_out("R1 current limit set again", S_ILIM, 0, 1);
    dir = 2'b11; tick(1);
    expect_out("R3 cleared by brake", S_NONE, 0, 0);
    dir = 2'b01; tick(1);
    expect_out("R9 no pulse leaving brake", S_NONE, 0, 0);

    // R3: coast clears
    ilim_c = 1; tick(ILIM_N + 1); ilim_c = 0;
    dir = 2'b00; tick(1);
    expect_out("R3 cleared by coast", S_NONE, 0, 0);
    dir = 2'b10; tick(WAKE_N + 1);
    expect_out("R9 pulse over after reverse start", S_NONE, 0, 0);

    // R4: overcurrent deglitch
    ocp_c = 1; tick(OCP_N - 1); ocp_c = 0; tick(2);
    expect_out("R4 short overcurrent glitch ignored", S_NONE, 0, 0);
    ocp_c = 1; tick(OCP_N + 1); ocp_c = 0;
    expect_out("R4 overcurrent latched, bridge off", S_OCP, 1, 1);

    // R5: survives sleep and wake
    dir = 2'b00; tick(3);
    expect_out("R5 overcurrent holds in sleep", S_OCP, 1, 1);
    dir = 2'b01; tick(WAKE_N + 2);
    expect_out("R5 overcurrent holds after wake", S_OCP, 1, 1);
    clr = 1; tick(1); clr = 0;
    expect_out("R5 overcurrent cleared by clear pulse", S_NONE, 0, 0);

    // R6: over-temperature
    ots_c = 1; tick(1);
    expect_out("R6 over-temperature disables bridge", S_OTS, 1, 1);
    clr = 1; tick(1); clr = 0;
    expect_out("R6 over-temperature ignores clear while present", S_OTS, 1, 1);
    ots_c = 0; tick(1);
    expect_out("R6 over-temperature auto resume", S_NONE, 0, 0);

    // R7: undervoltage
    uv_c = 1; tick(1);
    expect_out("R7 undervoltage disables bridge", S_UV, 1, 1);
    uv_c = 0; tick(1);
    expect_out("R7 undervoltage auto resume", S_NONE, 0, 0);

    // R8: summary bit with several sources
    ots_c = 1; uv_c = 1; tick(1);
    expect_out("R8 two live faults", S_OTS | S_UV, 1, 1);
    ots_c = 0; tick(1);
    expect_out("R8 one live fault left", S_UV, 1, 1);
    uv_c = 0; tick(1);
    expect_out("R8 all faults gone", S_NONE, 0, 0);

    tick(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule